// File: doc/BRIEF.md
# Six-Source Interrupt Enable and Poll Unit

This block is the interrupt request front end of a small 8-bit controller. It collects six request sources: two external pins, the overflow flags of timers 0 and 1, a serial port (receive or transmit), and timer 2, which requests on either its overflow flag or its external flag. An 8-bit enable register holds one enable bit per source and a global enable. Once per machine cycle the unit polls the masked requests, picks one by fixed priority and presents it to the CPU with a 3-bit vector index.

The CPU takes the request with an acknowledge pulse. The unit then clears the flag of that source when hardware is allowed to clear it, and it pulses a matching flag-clear output. It presents nothing new until the CPU reports the end of the service routine. The two timer 2 flags are kept inside the unit and only an explicit clear strobe removes them. Timer 0 and timer 1 flags become visible to the poll one machine cycle later than timer 2 flags, which matches when each timer sets its flag within the machine cycle.

A machine cycle ends with the clock in which `mc_tick` is high. An event input that is high in that same clock belongs to the next machine cycle.

Top module: `irq_poll_unit`

## Requirements
- R1: The enable register resets to 0. A write stores bits 7 and 5..0, and a read returns them. Bit 6 is not implemented and always reads 0. Bit i (i = 0..5) enables source i, and bit 7 is the global enable.
- R2: While the global enable is 0, `irq_req` is low and `irq_ack` has no effect. A request captured earlier is held and is shown again once the global enable returns to 1.
- R3: A source whose enable bit is 0 is never presented, even when its flag is pending.
- R4: The source codes are external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4 and timer 2 = 5. When several enabled sources are pending at a poll, `irq_idx` is the lowest code among them.
- R5: A poll happens in a clock with `mc_tick` high, and its result appears on `irq_req`/`irq_idx` one clock later. A timer 2 flag set before the tick of a machine cycle is polled at that tick. A timer 0 or timer 1 flag set before tick N is polled at tick N+1 at the earliest.
- R6: The timer 2 request is the OR of its overflow flag and its external flag. Acknowledge clears neither flag. `t2_clr` bit 0 clears the overflow flag and bit 1 clears the external flag. A set and a clear of the same flag in the same clock leave the flag set.
- R7: Acknowledge clears the flag of the acknowledged source when that source is timer 0, timer 1, or an external source in edge mode. In that clock `flag_clr` has exactly that source's bit set. For serial, timer 2 and level-mode external sources, `flag_clr` stays 0 and the request persists.
- R8: After an acknowledge, `irq_req` stays low until `irq_ret` is seen. The next request can be presented from the first poll after that.
- R9: With `ext_edge[k]`=1, a high-to-low change on `ext_n[k]` latches a request. With `ext_edge[k]`=0, the request is the low level of the pin at the poll.
- R10: A presented request keeps `irq_req` high and `irq_idx` stable until it is acknowledged, while the global enable stays 1 and no register write occurs.
- R11: After reset, `irq_req` is 0, `flag_clr` is 0 and `en_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | Marks the last clock of a machine cycle (poll point) |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register read data |
| ext_n | input | 2 | External request pins, active low |
| ext_edge | input | 2 | Per pin: 1 = edge mode, 0 = level mode |
| t0_ovf | input | 1 | Timer 0 overflow event pulse |
| t1_ovf | input | 1 | Timer 1 overflow event pulse |
| t2_ovf | input | 1 | Timer 2 overflow event pulse |
| t2_exf | input | 1 | Timer 2 external event pulse |
| t2_clr | input | 2 | Timer 2 flag clear strobes (bit 0 overflow, bit 1 external) |
| ser_ri | input | 1 | Serial receive flag level |
| ser_ti | input | 1 | Serial transmit flag level |
| irq_req | output | 1 | Request presented to the CPU |
| irq_idx | output | 3 | Vector index of the presented source |
| irq_ack | input | 1 | CPU acknowledge pulse |
| irq_ret | input | 1 | CPU return-from-service pulse |
| flag_clr | output | 6 | One-hot hardware flag clear, valid in the acknowledge clock |

## Verification
The hardest case to reach from the ports is a timer 0 flag and a timer 2 flag that become pending in the same machine cycle. The first poll has to choose the lower-priority timer 2 source, because timer 0 is not yet visible. After return from service, the next poll has to choose timer 0 while the timer 2 flag is still set. Directed sequences build this case by pulsing both overflows before one tick and then stepping through acknowledge and return. Another directed sequence pulses an event in the tick clock itself.

Directed sequences also set and clear a timer 2 flag in the same clock, and they drop the global enable while a captured request is waiting for acknowledge. A random phase then mixes events, acknowledges, returns and register writes against a bench model.

// File: rtl/irq_poll_pkg.sv
`timescale 1ns/1ps
package irq_poll_pkg;
   localparam int SRC_N   = 6;
   localparam int IDX_W   = 3;
   localparam int SLOT_SER = 4;
   localparam int SLOT_T2  = 5;
endpackage

// File: rtl/irq_ext_cell.sv
`timescale 1ns/1ps
// One external request pin: edge latch or level pass-through.
module irq_ext_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic edge_mode,
   input  logic clr,
   output logic req
);
   logic pin_d;
   logic lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_d <= 1'b1;
         lat_q <= 1'b0;
      end else begin
         pin_d <= pin_n;
         if (!edge_mode)
            lat_q <= 1'b0;
         else if (pin_d && !pin_n)
            lat_q <= 1'b1;
         else if (clr)
            lat_q <= 1'b0;
      end
   end

   assign req = edge_mode ? lat_q : ~pin_n;

   // R9
   edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && $fell(pin_n)) |=> (req || !edge_mode));
endmodule

// File: rtl/irq_aging_flag.sv
`timescale 1ns/1ps
// Sticky event flag; LATE variant becomes pollable one tick after it is set.
module irq_aging_flag #(
   parameter bit LATE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic tick,
   output logic vis
);
   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= set | (flag_q & ~clr);
   end

   generate
      if (LATE) begin : g_late
         logic aged_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    aged_q <= 1'b0;
            else if (clr)  aged_q <= 1'b0;
            else if (tick) aged_q <= flag_q;
         end
         assign vis = flag_q & aged_q;

         // R5
         late_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q) |-> !vis);
      end else begin : g_early
         logic unused_tick;
         assign unused_tick = tick;
         assign vis = flag_q;
      end
   endgenerate

   // R6
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vis && !clr) |=> vis);
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
// Fixed priority: lowest set index wins.
module irq_prio_pick #(
   parameter int N = 6,
   parameter int W = 3
) (
   input  logic [N-1:0] vec,
   output logic         any,
   output logic [W-1:0] idx
);
   initial begin
      width_fit_chk: assert ((1 << W) >= N) else $error("index width too small");
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = W'(i);
      end
   end

   assign any = |vec;

   // R4
   always_comb begin
      if (any) pick_hit_chk: assert (vec[idx]);
   end
endmodule

// File: rtl/irq_poll_unit.sv
`timescale 1ns/1ps
module irq_poll_unit #(
   parameter int EN_W       = 8,
   parameter int GLOBAL_BIT = 7,
   parameter int RSVD_BIT   = 6,
   parameter int EXT_N      = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               mc_tick,
   input  logic                               en_we,
   input  logic [EN_W-1:0]                    en_wdata,
   output logic [EN_W-1:0]                    en_rdata,
   input  logic [EXT_N-1:0]                   ext_n,
   input  logic [EXT_N-1:0]                   ext_edge,
   input  logic                               t0_ovf,
   input  logic                               t1_ovf,
   input  logic                               t2_ovf,
   input  logic                               t2_exf,
   input  logic [1:0]                         t2_clr,
   input  logic                               ser_ri,
   input  logic                               ser_ti,
   output logic                               irq_req,
   output logic [irq_poll_pkg::IDX_W-1:0]     irq_idx,
   input  logic                               irq_ack,
   input  logic                               irq_ret,
   output logic [irq_poll_pkg::SRC_N-1:0]     flag_clr
);
   localparam int SRC_N = irq_poll_pkg::SRC_N;
   localparam int IDX_W = irq_poll_pkg::IDX_W;
   localparam logic [EN_W-1:0] EN_MASK = ~({{(EN_W-1){1'b0}}, 1'b1} << RSVD_BIT);
   localparam logic [SRC_N-1:0] ONE_HOT0 = {{(SRC_N-1){1'b0}}, 1'b1};

   initial begin
      en_width_chk:  assert (EN_W == 8) else $error("enable register must be 8 bits");
      global_pos_chk: assert (GLOBAL_BIT == EN_W - 1) else $error("global enable must be the MSB");
      rsvd_pos_chk:  assert (RSVD_BIT == SRC_N) else $error("reserved bit must sit above the source bits");
      ext_count_chk: assert (EXT_N == 2) else $error("two external sources expected");
   end

   logic [EN_W-1:0]  en_q;
   logic             ea;
   logic [SRC_N-1:0] vis;
   logic [SRC_N-1:0] clr_vec;
   logic [SRC_N-1:0] masked;
   logic [SRC_N-1:0] auto_m;
   logic [SRC_N-1:0] idx_hot;
   logic             pick_any;
   logic [IDX_W-1:0] pick_idx;
   logic             req_q;
   logic [IDX_W-1:0] idx_q;
   logic             busy_q;
   logic             ack_fire;
   logic [1:0]       tmr_set;
   logic [1:0]       t2_set;
   logic [1:0]       t2_vis;

   // enable register
   always_ff @(posedge clk) begin
      if (!rst_n)     en_q <= '0;
      else if (en_we) en_q <= en_wdata & EN_MASK;
   end
   assign en_rdata = en_q;
   assign ea       = en_q[GLOBAL_BIT];

   // source flags
   generate
      for (genvar g = 0; g < EXT_N; g++) begin : g_ext
         irq_ext_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[g]),
            .edge_mode (ext_edge[g]),
            .clr       (clr_vec[2*g]),
            .req       (vis[2*g])
         );
      end
   endgenerate

   assign tmr_set = {t1_ovf, t0_ovf};
   generate
      for (genvar g = 0; g < 2; g++) begin : g_tmr
         irq_aging_flag #(.LATE(1'b1)) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (tmr_set[g]),
            .clr   (clr_vec[2*g+1]),
            .tick  (mc_tick),
            .vis   (vis[2*g+1])
         );
      end
   endgenerate

   assign t2_set = {t2_exf, t2_ovf};
   generate
      for (genvar g = 0; g < 2; g++) begin : g_t2
         irq_aging_flag #(.LATE(1'b0)) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (t2_set[g]),
            .clr   (t2_clr[g]),
            .tick  (mc_tick),
            .vis   (t2_vis[g])
         );
      end
   endgenerate

   assign vis[irq_poll_pkg::SLOT_SER] = ser_ri | ser_ti;
   assign vis[irq_poll_pkg::SLOT_T2]  = |t2_vis;

   // poll and arbitration
   assign masked = vis & en_q[SRC_N-1:0];

   irq_prio_pick #(.N(SRC_N), .W(IDX_W)) u_pick (
      .vec (masked),
      .any (pick_any),
      .idx (pick_idx)
   );

   assign irq_req  = req_q & ea;
   assign irq_idx  = idx_q;
   assign ack_fire = irq_ack & irq_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         idx_q  <= '0;
         busy_q <= 1'b0;
      end else if (ack_fire) begin
         req_q  <= 1'b0;
         busy_q <= 1'b1;
      end else begin
         if (irq_ret) busy_q <= 1'b0;
         if (mc_tick && !req_q && !busy_q && ea) begin
            req_q <= pick_any;
            idx_q <= pick_idx;
         end
      end
   end

   // hardware flag clearing on acknowledge
   assign auto_m   = {2'b00, 1'b1, ext_edge[1], 1'b1, ext_edge[0]};
   assign idx_hot  = ONE_HOT0 << idx_q;
   assign clr_vec  = ack_fire ? (idx_hot & auto_m) : '0;
   assign flag_clr = clr_vec;

   // R4
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_idx < 3'd6));
   // R8
   ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> !irq_req);
   // R8
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !irq_ret) |=> !irq_req);
   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_ack && !en_we) |=> (irq_req && $stable(irq_idx)));
   // R7
   clr_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|flag_clr) |-> (irq_ack && irq_req && $onehot0(flag_clr)));
endmodule

// File: tb/irq_poll_unit_tb_top.sv
`timescale 1ns/1ps
module irq_poll_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_tick = 1'b0;
   logic       en_we = 1'b0;
   logic [7:0] en_wdata = '0;
   logic [7:0] en_rdata;
   logic [1:0] ext_n = 2'b11;
   logic [1:0] ext_edge = 2'b00;
   logic       t0_ovf = 1'b0, t1_ovf = 1'b0, t2_ovf = 1'b0, t2_exf = 1'b0;
   logic [1:0] t2_clr = 2'b00;
   logic       ser_ri = 1'b0, ser_ti = 1'b0;
   logic       irq_req;
   logic [2:0] irq_idx;
   logic       irq_ack = 1'b0, irq_ret = 1'b0;
   logic [5:0] flag_clr;

   int n_chk = 0;
   int n_fail = 0;

   // bench model of the requirements
   logic [7:0] m_en = '0;
   logic [1:0] m_e = '0, m_pin = 2'b11, m_t = '0, m_ta = '0;
   logic       m_t2o = 1'b0, m_t2e = 1'b0;
   logic       m_req = 1'b0, m_busy = 1'b0;
   logic [2:0] m_idx = '0;

   always #2.5 clk = ~clk;

   irq_poll_unit dut_i (
      .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .en_we(en_we), .en_wdata(en_wdata),
      .en_rdata(en_rdata), .ext_n(ext_n), .ext_edge(ext_edge), .t0_ovf(t0_ovf),
      .t1_ovf(t1_ovf), .t2_ovf(t2_ovf), .t2_exf(t2_exf), .t2_clr(t2_clr),
      .ser_ri(ser_ri), .ser_ti(ser_ti), .irq_req(irq_req), .irq_idx(irq_idx),
      .irq_ack(irq_ack), .irq_ret(irq_ret), .flag_clr(flag_clr)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] m_vis();
      logic [5:0] v;
      v[0] = ext_edge[0] ? m_e[0] : ~ext_n[0];
      v[1] = m_t[0] & m_ta[0];
      v[2] = ext_edge[1] ? m_e[1] : ~ext_n[1];
      v[3] = m_t[1] & m_ta[1];
      v[4] = ser_ri | ser_ti;
      v[5] = m_t2o | m_t2e;
      return v;
   endfunction

   function automatic logic [5:0] m_clr();
      logic [5:0] hw;
      hw = {2'b00, 1'b1, ext_edge[1], 1'b1, ext_edge[0]};
      if (irq_ack && m_req && m_en[7]) return (6'd1 << m_idx) & hw;
      return 6'd0;
   endfunction

   task automatic m_update();
      logic [5:0] v, c, mv;
      logic       fire, poll;
      logic [2:0] win;
      logic [1:0] tset;
      v    = m_vis();
      c    = m_clr();
      fire = irq_ack && m_req && m_en[7];
      poll = mc_tick && !m_req && !m_busy && m_en[7];
      mv   = v & m_en[5:0];
      win  = 3'd0;
      for (int i = 5; i >= 0; i--) if (mv[i]) win = 3'(i);
      tset = {t1_ovf, t0_ovf};
      for (int g = 0; g < 2; g++) begin
         m_e[g]   = ext_edge[g] ? ((m_pin[g] & ~ext_n[g]) | (m_e[g] & ~c[2*g])) : 1'b0;
         m_pin[g] = ext_n[g];
         if (c[2*g+1]) m_ta[g] = 1'b0;
         else if (mc_tick) m_ta[g] = m_t[g];
         m_t[g] = tset[g] | (m_t[g] & ~c[2*g+1]);
      end
      m_t2o = t2_ovf | (m_t2o & ~t2_clr[0]);
      m_t2e = t2_exf | (m_t2e & ~t2_clr[1]);
      if (fire) begin
         m_req  = 1'b0;
         m_busy = 1'b1;
      end else begin
         if (irq_ret) m_busy = 1'b0;
         if (poll) begin
            m_req = |mv;
            m_idx = win;
         end
      end
      if (en_we) m_en = en_wdata & 8'hBF;
   endtask

   // inputs are driven at a falling edge; one call covers one clock
   task automatic cyc(input string tag);
      #1;
      chk({tag, " R7 flag_clr"}, flag_clr, m_clr());
      m_update();
      @(posedge clk);
      @(negedge clk);
      chk({tag, " R2 irq_req"}, irq_req, m_req & m_en[7]);
      if (irq_req) chk({tag, " R4 irq_idx"}, irq_idx, m_idx);
      chk({tag, " R1 en_rdata"}, en_rdata, m_en);
      mc_tick = 0; en_we = 0; irq_ack = 0; irq_ret = 0;
      t0_ovf = 0; t1_ovf = 0; t2_ovf = 0; t2_exf = 0; t2_clr = 2'b00;
   endtask

   task automatic tick(input string tag);
      mc_tick = 1;
      cyc(tag);
   endtask

   task automatic wr(input logic [7:0] d);
      en_we = 1;
      en_wdata = d;
      cyc("wr");
   endtask

   task automatic ack_ret();
      irq_ack = 1;
      cyc("ack");
      irq_ret = 1;
      cyc("ret");
   endtask

   initial begin
      #(5.0 * 200000);
      n_fail++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (4) @(negedge clk);
      rst_n = 1;
      #1;
      // R11 reset state
      chk("R11 irq_req", irq_req, 0);
      chk("R11 flag_clr", flag_clr, 0);
      chk("R11 en_rdata", en_rdata, 0);
      @(negedge clk);

      // R1 reserved bit
      wr(8'hFF);
      chk("R1 rsvd write", en_rdata, 8'hBF);
      wr(8'h40);
      chk("R1 rsvd only", en_rdata, 8'h00);

      // R2 global enable, R6 timer 2 flags, R8 service lockout
      wr(8'h3F);
      t2_ovf = 1; cyc("R2");
      tick("R2"); tick("R2");
      chk("R2 masked by global", irq_req, 0);
      wr(8'hBF);
      tick("R2");
      chk("R2 after enable", irq_req, 1);
      chk("R2 idx", irq_idx, 5);
      wr(8'h3F);
      chk("R2 hidden", irq_req, 0);
      irq_ack = 1; cyc("R2 ack ignored");
      wr(8'hBF);
      chk("R2 held request", irq_req, 1);
      chk("R2 held idx", irq_idx, 5);
      irq_ack = 1;
      #1 chk("R7 t2 not cleared", flag_clr, 0);
      cyc("R7");
      chk("R8 drop on ack", irq_req, 0);
      tick("R8"); tick("R8");
      chk("R8 no request in service", irq_req, 0);
      irq_ret = 1; cyc("R8");
      tick("R6");
      chk("R6 flag survives ack", irq_req, 1);
      chk("R6 idx", irq_idx, 5);
      ack_ret();
      t2_clr = 2'b01; cyc("R6");
      tick("R6");
      chk("R6 cleared by write", irq_req, 0);
      t2_exf = 1; t2_clr = 2'b10; cyc("R6");
      tick("R6");
      chk("R6 set wins over clear", irq_req, 1);
      chk("R6 ext flag idx", irq_idx, 5);
      ack_ret();
      t2_clr = 2'b11; cyc("R6");

      // R5 poll timing of timer 0 against timer 2
      t0_ovf = 1; t2_ovf = 1; cyc("R5");
      tick("R5");
      chk("R5 t2 polled same cycle", irq_req, 1);
      chk("R5 t0 not yet visible", irq_idx, 5);
      ack_ret();
      tick("R5");
      chk("R5 t0 next cycle", irq_idx, 1);
      irq_ack = 1;
      #1 chk("R7 t0 hw clear", flag_clr, 6'b000010);
      cyc("R7");
      irq_ret = 1; cyc("R5");
      tick("R5");
      chk("R5 t0 gone", irq_idx, 5);
      ack_ret();
      t2_clr = 2'b11; cyc("R5");
      t2_ovf = 1; mc_tick = 1; cyc("R5");
      chk("R5 event in tick clock", irq_req, 0);
      tick("R5");
      chk("R5 next tick", irq_req, 1);
      ack_ret();
      t2_clr = 2'b11; cyc("R5");
      t1_ovf = 1; cyc("R5");
      tick("R5");
      chk("R5 t1 first tick", irq_req, 0);
      tick("R5");
      chk("R5 t1 second tick", irq_idx, 3);
      ack_ret();

      // R4 priority, R3 per-source enable
      ext_edge = 2'b00; ext_n = 2'b01; ser_ri = 1;
      wr(8'h94);
      tick("R4");
      chk("R4 ext1 over serial", irq_idx, 2);
      irq_ack = 1;
      #1 chk("R7 level ext kept", flag_clr, 0);
      cyc("R7");
      irq_ret = 1; cyc("R3");
      wr(8'h90);
      tick("R3");
      chk("R3 ext1 masked", irq_idx, 4);
      irq_ack = 1;
      #1 chk("R7 serial kept", flag_clr, 0);
      cyc("R7");
      irq_ret = 1; cyc("R3");
      wr(8'h80);
      tick("R3");
      chk("R3 all masked", irq_req, 0);
      ext_n = 2'b11; ser_ri = 0; cyc("R3");

      // R9 edge and level, R10 hold
      ext_edge = 2'b01;
      wr(8'h81);
      ext_n[0] = 0; cyc("R9");
      ext_n[0] = 1; cyc("R9");
      tick("R9");
      chk("R9 edge latched", irq_idx, 0);
      chk("R9 edge req", irq_req, 1);
      cyc("R10"); cyc("R10"); tick("R10");
      chk("R10 held", irq_req, 1);
      chk("R10 idx stable", irq_idx, 0);
      irq_ack = 1;
      #1 chk("R7 edge ext clear", flag_clr, 6'b000001);
      cyc("R7");
      irq_ret = 1; cyc("R9");
      tick("R9");
      chk("R9 edge cleared", irq_req, 0);
      ext_edge = 2'b00; ext_n[0] = 0;
      tick("R9");
      chk("R9 level req", irq_idx, 0);
      irq_ack = 1; cyc("R9");
      ext_n[0] = 1;
      irq_ret = 1; cyc("R9");
      tick("R9");
      chk("R9 level released", irq_req, 0);

      // random phase against the model
      for (int n = 0; n < 4000; n++) begin
         if (n % 512 == 0) ext_edge = 2'($urandom);
         mc_tick = (n % 4 == 3);
         t0_ovf  = ($urandom % 16) == 0;
         t1_ovf  = ($urandom % 16) == 0;
         t2_ovf  = ($urandom % 24) == 0;
         t2_exf  = ($urandom % 24) == 0;
         t2_clr  = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
         if (($urandom % 8) == 0) ext_n[$urandom % 2] ^= 1'b1;
         if (($urandom % 20) == 0) ser_ri = ~ser_ri;
         if (($urandom % 20) == 0) ser_ti = ~ser_ti;
         if (($urandom % 40) == 0) begin
            en_we = 1;
            en_wdata = 8'($urandom);
            if (($urandom % 8) != 0) en_wdata[7] = 1'b1;
         end
         irq_ack = ($urandom % 3) == 0;
         irq_ret = ($urandom % 8) == 0;
         cyc("RND R4 R5 R7");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule